// File: doc/BRIEF.md
# Dual-Channel External Interrupt Edge Detector

This block watches two asynchronous interrupt pins and turns chosen transitions on them into sticky request flags. Each pin passes through a two-flop synchronizer. A per-channel 2-bit mode then selects one of four behaviours: off, high-to-low, low-to-high, or any change.

Detection runs only on machine-cycle boundaries, which a single-clock enable pulse marks. On each enabled edge the synchronized level is compared with the level captured at the previous boundary. A matching transition sets the channel's flag. The flag is copied to a pending output at the following boundary, so the controller sees a request one machine cycle after it is latched.

Software programs the modes through a write-only 8-bit configuration port and clears flags with a per-channel clear strobe.

Top module: `ext_irq_edge_unit`

## Requirements
- R1: After reset both flags and both pending outputs are 0 and both channels are off (mode 00), so pin activity sets no flag until a mode is written.
- R2: Mode 01 sets the channel flag on a 1-to-0 transition of its pin and ignores 0-to-1 transitions.
- R3: Mode 10 sets the channel flag on a 0-to-1 transition of its pin and ignores 1-to-0 transitions.
- R4: Mode 11 sets the channel flag on either transition of its pin.
- R5: Mode 00 sets no flag, whatever the pin does.
- R6: Configuration bits [1:0] hold the channel 0 mode and bits [3:2] hold the channel 1 mode. Writing 8'b0000_0101 puts both channels in mode 01, and each pin affects only its own flag.
- R7: A flag changes from 0 to 1 only at a clock edge where the machine-cycle enable is high. A pin change made just after a boundary, with a machine cycle of 3 or more clocks, sets the flag at the next boundary.
- R8: The pending output rises only at a boundary where the flag was already set before that edge, so pending follows flag one machine cycle later.
- R9: A set flag stays set until its clear strobe is high for one clock. The clear drops both the flag and the pending output of that channel.
- R10: When an enabled edge is detected in the same clock as the channel's clear strobe, the flag stays set.
- R11: Writing mode 00 to a channel whose flag is set leaves the flag set.
- R12: Configuration bits [7:4] have no effect on detection.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| mcyc_en | input | 1 | One-clock pulse marking a machine-cycle boundary |
| pin_i | input | 2 | Asynchronous interrupt pins, bit n is channel n |
| cfg_we | input | 1 | Write strobe for the mode configuration |
| cfg_wdata | input | 8 | Configuration data; [1:0] channel 0 mode, [3:2] channel 1 mode |
| clr_i | input | 2 | Per-channel flag clear strobe |
| flag_o | output | 2 | Latched request flags |
| pend_o | output | 2 | Requests visible to the controller |

## Verification
Each mode is driven with both a rising and a falling pin change. This separates the mode that should respond from the one that should stay quiet, and shows whether the polarity is decoded the right way round. Pins on the two channels are moved together under asymmetric configurations, including ones with junk in the upper nibble. These cases expose swapped field positions and any decoding of the unused bits. A clear strobe placed exactly on the detecting boundary, and a mode switched off while a flag is set, exercise the priority and retention rules. A twelve-cycle service wait checks that the request stays pending until it is acknowledged.

// File: rtl/eirq_pkg.sv
package eirq_pkg;

  typedef enum logic [1:0] {
    EDGE_OFF  = 2'b00,
    EDGE_FALL = 2'b01,
    EDGE_RISE = 2'b10,
    EDGE_ANY  = 2'b11
  } edge_mode_e;

  // Decide whether a transition from prev to cur matches the selected mode.
  function automatic logic edge_match(edge_mode_e mode, logic prev, logic cur);
    logic rise;
    logic fall;
    rise = ~prev & cur;
    fall = prev & ~cur;
    case (mode)
      EDGE_FALL: edge_match = fall;
      EDGE_RISE: edge_match = rise;
      EDGE_ANY:  edge_match = rise | fall;
      default:   edge_match = 1'b0;
    endcase
  endfunction

endpackage

// File: rtl/eirq_sync.sv
module eirq_sync #(
  parameter int WIDTH  = 2,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] async_i,
  output logic [WIDTH-1:0] sync_o
);

  logic [WIDTH-1:0] stage_q [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < STAGES; i++) stage_q[i] <= '0;
    end else begin
      stage_q[0] <= async_i;
      for (int i = 1; i < STAGES; i++) stage_q[i] <= stage_q[i-1];
    end
  end

  assign sync_o = stage_q[STAGES-1];

endmodule

// File: rtl/eirq_chan.sv
module eirq_chan
  import eirq_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       mcyc_en,
  input  logic       pin_s,
  input  edge_mode_e mode,
  input  logic       clr,
  output logic       hit,
  output logic       flag,
  output logic       pend
);

  logic last_q;

  // Level captured at the previous machine-cycle boundary
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       last_q <= 1'b0;
    else if (mcyc_en) last_q <= pin_s;
  end

  assign hit = mcyc_en & edge_match(mode, last_q, pin_s);

  // Sticky flag: a detection beats a simultaneous clear
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   flag <= 1'b0;
    else if (hit) flag <= 1'b1;
    else if (clr) flag <= 1'b0;
  end

  // Request becomes visible one machine cycle after latching
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       pend <= 1'b0;
    else if (clr)     pend <= 1'b0;
    else if (mcyc_en) pend <= flag;
  end

  // R7
  flag_on_boundary_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flag) |-> $past(mcyc_en));

  // R8
  pend_after_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pend) |-> ($past(flag) && $past(mcyc_en)));

  // R9
  flag_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (flag && !clr) |=> flag);

  // R10
  hit_beats_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (hit && clr) |=> flag);

  // R5
  off_no_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == EDGE_OFF && !flag) |=> !flag);

endmodule

// File: rtl/ext_irq_edge_unit.sv
module ext_irq_edge_unit
  import eirq_pkg::*;
#(
  parameter int NCH     = 2,
  parameter int FIELD_W = 2,
  parameter int CFG_W   = 8,
  parameter int SYNC_N  = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             mcyc_en,
  input  logic [NCH-1:0]   pin_i,
  input  logic             cfg_we,
  input  logic [CFG_W-1:0] cfg_wdata,
  input  logic [NCH-1:0]   clr_i,
  output logic [NCH-1:0]   flag_o,
  output logic [NCH-1:0]   pend_o
);

  localparam int MODE_BITS = NCH * FIELD_W;

  logic [MODE_BITS-1:0] mode_q;
  logic [NCH-1:0]       pin_s;
  logic [NCH-1:0]       hit_w;
  logic                 unused_cfg_hi;

  assign unused_cfg_hi = ^cfg_wdata[CFG_W-1:MODE_BITS];

  // Write-only mode store; bits above the mode fields are dropped
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      mode_q <= '0;
    else if (cfg_we) mode_q <= cfg_wdata[MODE_BITS-1:0];
  end

  // R12
  cfg_low_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_we |=> $stable(mode_q));

  eirq_sync #(.WIDTH(NCH), .STAGES(SYNC_N)) u_sync (
    .clk    (clk),
    .rst_n  (rst_n),
    .async_i(pin_i),
    .sync_o (pin_s)
  );

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    eirq_chan u_chan (
      .clk    (clk),
      .rst_n  (rst_n),
      .mcyc_en(mcyc_en),
      .pin_s  (pin_s[c]),
      .mode   (edge_mode_e'(mode_q[c*FIELD_W +: FIELD_W])),
      .clr    (clr_i[c]),
      .hit    (hit_w[c]),
      .flag   (flag_o[c]),
      .pend   (pend_o[c])
    );
  end

  // R7
  hits_on_boundary_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (hit_w != '0) |-> mcyc_en);

endmodule

// File: tb/ext_irq_edge_unit_bench.sv
module ext_irq_edge_unit_bench;

  localparam int DIV = 4;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       mcyc_en;
  logic [1:0] pin_i = 2'b00;
  logic       cfg_we = 1'b0;
  logic [7:0] cfg_wdata = 8'h00;
  logic [1:0] clr_i = 2'b00;
  logic [1:0] flag_o;
  logic [1:0] pend_o;
  logic [1:0] div_cnt = 2'd0;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  always @(negedge clk) div_cnt <= div_cnt + 2'd1;
  assign mcyc_en = rst_n && (div_cnt == 2'd3);

  ext_irq_edge_unit u_ext_irq_edge_unit (
    .clk(clk), .rst_n(rst_n), .mcyc_en(mcyc_en), .pin_i(pin_i),
    .cfg_we(cfg_we), .cfg_wdata(cfg_wdata), .clr_i(clr_i),
    .flag_o(flag_o), .pend_o(pend_o)
  );

  task automatic check(string req, logic [1:0] act, logic [1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %b expected %b", req, act, exp);
    end
  endtask

  // Land on the negedge just after a machine-cycle boundary
  task automatic align();
    do @(posedge clk); while (!mcyc_en);
    @(negedge clk);
  endtask

  task automatic mcs(int n);
    repeat (n * DIV) @(negedge clk);
  endtask

  task automatic write_cfg(logic [7:0] v);
    cfg_we = 1'b1; cfg_wdata = v;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic clear(logic [1:0] m);
    clr_i = m;
    @(negedge clk);
    clr_i = 2'b00;
  endtask

  task automatic drive_pins(logic [1:0] v);
    align();
    pin_i = v;
  endtask

  task automatic t_reset();
    check("R1 flag after reset", flag_o, 2'b00);
    check("R1 pend after reset", pend_o, 2'b00);
    drive_pins(2'b11); mcs(2);
    check("R1 default mode off rise", flag_o, 2'b00);
    drive_pins(2'b00); mcs(2);
    check("R5 off mode fall", flag_o, 2'b00);
  endtask

  task automatic t_falling();
    write_cfg(8'b0000_0101);
    drive_pins(2'b01); mcs(2);
    check("R2 fall mode ignores rise", flag_o, 2'b00);
    drive_pins(2'b00); mcs(1);
    check("R7 flag at next boundary", flag_o, 2'b01);
    check("R8 pend not yet", pend_o, 2'b00);
    check("R6 channel 1 untouched", flag_o & 2'b10, 2'b00);
    mcs(1);
    check("R8 pend one cycle later", pend_o, 2'b01);
    clear(2'b01);
    check("R9 clear drops flag", flag_o, 2'b00);
    check("R9 clear drops pend", pend_o, 2'b00);
  endtask

  task automatic t_rising();
    write_cfg(8'b0000_1010);
    drive_pins(2'b10); mcs(2);
    check("R3 rise mode catches rise", flag_o, 2'b10);
    clear(2'b10);
    drive_pins(2'b00); mcs(2);
    check("R3 rise mode ignores fall", flag_o, 2'b00);
  endtask

  task automatic t_both();
    write_cfg(8'b0000_1111);
    drive_pins(2'b01); mcs(2);
    check("R4 any mode rise", flag_o, 2'b01);
    clear(2'b11);
    drive_pins(2'b00); mcs(2);
    check("R4 any mode fall", flag_o, 2'b01);
    clear(2'b11);
  endtask

  task automatic t_fields();
    write_cfg(8'b0000_0010);
    drive_pins(2'b11); mcs(2);
    check("R6 low field is channel 0", flag_o, 2'b01);
    clear(2'b11);
    write_cfg(8'b1111_0100);
    drive_pins(2'b00); mcs(2);
    check("R12 upper nibble ignored", flag_o, 2'b10);
    check("R12 pend matches", pend_o, 2'b10);
    clear(2'b11);
  endtask

  task automatic t_sticky_and_off();
    write_cfg(8'b0000_0011);
    drive_pins(2'b01); mcs(1);
    check("R7 any mode flag set", flag_o, 2'b01);
    mcs(6);
    check("R9 flag held without clear", flag_o, 2'b01);
    write_cfg(8'b0000_0000);
    mcs(2);
    check("R11 off keeps flag", flag_o, 2'b01);
    check("R11 off keeps pend", pend_o, 2'b01);
    clear(2'b01);
    drive_pins(2'b00); mcs(2);
    check("R5 off after clear", flag_o, 2'b00);
  endtask

  task automatic t_race();
    write_cfg(8'b0000_0011);
    drive_pins(2'b01); mcs(2);
    check("R10 setup flag", flag_o, 2'b01);
    align();
    pin_i = 2'b00;
    repeat (DIV - 1) @(negedge clk);
    clr_i = 2'b01;
    @(negedge clk);
    clr_i = 2'b00;
    check("R10 detection beats clear", flag_o, 2'b01);
    clear(2'b01);
    check("R9 later clear works", flag_o, 2'b00);
  endtask

  task automatic t_service();
    write_cfg(8'b0000_1000);
    drive_pins(2'b10);
    mcs(12);
    check("R8 request still pending at ack", pend_o, 2'b10);
    clear(2'b10);
    check("R9 acknowledged flag", flag_o, 2'b00);
    check("R9 acknowledged pend", pend_o, 2'b00);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_falling();
    t_rising();
    t_both();
    t_fields();
    t_sticky_and_off();
    t_race();
    t_service();
    if (!done) begin
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule